// File: doc/BRIEF.md
# Heartbeat Watchdog with Supply-Fail Override

This block supervises a processor by watching a heartbeat line that firmware must toggle. A transition in either direction counts as a service event. If no transition arrives within a programmable period, given as a clock frequency and a period in milliseconds (by default 1.6 s at 50 MHz), an active-low watchdog flag drops. The flag is usually wired to a non-maskable interrupt or to a manual-reset input elsewhere.

Counting is suspended while the system reset from the reset generator is active, and while the heartbeat is marked as disconnected. In both cases the count is held at zero. A supply-good input overrides everything: when it goes false, the flag is pulled low in the same cycle. With the heartbeat disconnected, the flag therefore reports supply faults only and works as a low-line indicator.

The control is a three-state machine. `WD_HOLD` means the count is held at zero. `WD_RUN` means the count is advancing. `WD_TRIPPED` means the period has expired and the flag is low. The transitions are as follows. HOLD→RUN happens when reset and disconnect are both released. RUN→TRIPPED happens when the count is at its limit and no edge is seen. TRIPPED→RUN happens on a heartbeat edge. Any state goes to HOLD while reset or disconnect is active.

Top module: `hb_watchdog`

## Requirements
- R1: With the limit T = CLK_FREQ_HZ*PERIOD_MS/1000 cycles, the flag goes low T+1 rising clock edges after reset and disconnect are released, if no heartbeat edge is seen.
- R2: A heartbeat change, rising or falling, that is applied after rising edge k clears the count at rising edge k+3, because of two synchronizer stages and one history flop. The next trip then falls at edge k+3+T.
- R3: While sys_rst is 1, the machine stays in WD_HOLD with the count at zero, and the flag never drops for a timeout. After release, timing restarts as in R1.
- R4: While hb_float is 1, the machine stays in WD_HOLD with the count at zero, whatever the heartbeat does.
- R5: Counting starts at the first rising edge at which sys_rst and hb_float are both 0. The count is 0 in the first WD_RUN cycle.
- R6: When pwr_ok is 0, wdog_n is 0 in the same cycle, whatever the state. A supply dip does not disturb the count.
- R7: With hb_float held at 1, wdog_n equals pwr_ok.
- R8: After a trip, the first heartbeat edge returns wdog_n high and restarts the count from zero, so the next trip comes T cycles after that edge takes effect.
- R9: After rst_n with pwr_ok at 1, wdog_n is 1 and the state is WD_HOLD.
- R10: A heartbeat that toggles every P cycles never trips when P ≤ T. When P = T+1, it trips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| hb_in | input | 1 | Heartbeat line from the processor, asynchronous |
| hb_float | input | 1 | 1 = heartbeat not driven; counting is suspended |
| sys_rst | input | 1 | 1 = processor held in reset by the reset generator |
| pwr_ok | input | 1 | 1 = supply above threshold |
| wdog_n | output | 1 | Active-low watchdog flag |

## Verification
A count that is stuck, or that is cleared one cycle early or late, moves the first falling edge of wdog_n away from its computed edge T+1 or d+3+T. This shows up within one timeout period, so the sweeps over the toggle delay d and the toggle period P expose it. A machine that stays in WD_TRIPPED, or that fails to return to WD_HOLD, shows up as a missing recovery edge at d+3, or as a flag that drops while sys_rst or hb_float is held. A wrong supply path shows in the very cycle in which pwr_ok falls.

// File: rtl/hb_wd_pkg.sv
package hb_wd_pkg;

    typedef enum logic [1:0] {
        WD_HOLD    = 2'd0,
        WD_RUN     = 2'd1,
        WD_TRIPPED = 2'd2
    } wd_state_t;

    // Timeout in clock cycles from a frequency and a period in milliseconds.
    function automatic int unsigned wd_cycles(input longint unsigned freq_hz,
                                              input longint unsigned period_ms);
        longint unsigned prod;
        prod = (freq_hz * period_ms) / 64'd1000;
        return prod[31:0];
    endfunction

endpackage

// File: rtl/hb_wd_sync.sv
// Multi-stage synchronizer plus history flop; flags a change of level.
module hb_wd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic change
);
    logic [STAGES-1:0] chain;
    logic              hist;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= 1'b0;
        else        hist <= chain[STAGES-1];
    end

    assign level  = chain[STAGES-1];
    assign change = chain[STAGES-1] ^ hist;

    // R2: a flagged change is followed by the history flop taking the new level
    a_r2_change_latched: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> (hist == $past(level)));

endmodule

// File: rtl/hb_wd_counter.sv
// Cycle counter with synchronous clear and terminal flag.
module hb_wd_counter #(
    parameter int unsigned LIMIT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       inc,
    output logic [$clog2(LIMIT)-1:0]   cnt,
    output logic                       at_limit
);
    localparam int unsigned CW = $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (inc && cnt != LAST) cnt <= cnt + CW'(1);
    end

    assign at_limit = (cnt == LAST);

    // R3/R4: a clear request leaves the count at zero
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R5: each counting cycle below the limit advances by exactly one
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !at_limit) |=> (cnt == $past(cnt) + CW'(1)));

endmodule

// File: rtl/hb_wd_fsm.sv
// Hold / run / tripped controller and flag output.
module hb_wd_fsm
    import hb_wd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold,
    input  logic      hb_edge,
    input  logic      at_limit,
    input  logic      pwr_ok,
    output wd_state_t state,
    output logic      cnt_clr,
    output logic      cnt_inc,
    output logic      wdog_n
);
    wd_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            WD_HOLD: begin
                if (!hold) nxt = WD_RUN;
            end
            WD_RUN: begin
                if (hold)                       nxt = WD_HOLD;
                else if (at_limit && !hb_edge)  nxt = WD_TRIPPED;
            end
            WD_TRIPPED: begin
                if (hold)         nxt = WD_HOLD;
                else if (hb_edge) nxt = WD_RUN;
            end
            default: nxt = WD_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WD_HOLD;
        else        state <= nxt;
    end

    always_comb begin
        cnt_clr = 1'b1;
        cnt_inc = 1'b0;
        wdog_n  = pwr_ok;
        unique case (state)
            WD_HOLD: begin
                cnt_clr = 1'b1;
            end
            WD_RUN: begin
                cnt_clr = hold || hb_edge;
                cnt_inc = 1'b1;
            end
            WD_TRIPPED: begin
                cnt_clr = 1'b1;
                wdog_n  = 1'b0;
            end
            default: begin
                cnt_clr = 1'b1;
            end
        endcase
    end

    // R3/R4: reset or disconnect always lands the machine in HOLD
    a_r3_hold_entered: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (state == WD_HOLD));

    // R6: a supply fault is visible on the flag in the same cycle
    a_r6_supply_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> !wdog_n);

endmodule

// File: rtl/hb_watchdog.sv
// Top: heartbeat watchdog with supply-fail override.
module hb_watchdog
    import hb_wd_pkg::*;
#(
    parameter longint unsigned CLK_FREQ_HZ = 64'd50_000_000,
    parameter longint unsigned PERIOD_MS   = 64'd1600,
    parameter int unsigned     SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_in,
    input  logic hb_float,
    input  logic sys_rst,
    input  logic pwr_ok,
    output logic wdog_n
);
    localparam int unsigned LIMIT = wd_cycles(CLK_FREQ_HZ, PERIOD_MS);
    localparam int unsigned CW    = $clog2(LIMIT);

    logic          hb_level;
    logic          hb_edge;
    logic          hold;
    logic          cnt_clr;
    logic          cnt_inc;
    logic          at_limit;
    logic [CW-1:0] cnt;
    wd_state_t     state;

    assign hold = sys_rst | hb_float;

    hb_wd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (hb_in),
        .level  (hb_level),
        .change (hb_edge)
    );

    hb_wd_counter #(.LIMIT(LIMIT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .cnt      (cnt),
        .at_limit (at_limit)
    );

    hb_wd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .hb_edge  (hb_edge),
        .at_limit (at_limit),
        .pwr_ok   (pwr_ok),
        .state    (state),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .wdog_n   (wdog_n)
    );

    // R1: a trip is entered only from RUN with the count at its last value
    a_r1_trip_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_TRIPPED && $past(state) == WD_RUN) |-> ($past(cnt) == CW'(LIMIT - 1)));

    // R8: an edge in TRIPPED resumes counting from zero
    a_r8_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_TRIPPED && hb_edge && !hold) |=> (state == WD_RUN && cnt == '0));

    // R4/R7: while disconnected the flag follows the supply flag only
    a_r7_lowline: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_float && $past(hb_float)) |-> (wdog_n == pwr_ok));

    logic unused_level;
    assign unused_level = hb_level;

endmodule

// File: tb/hb_watchdog_test.sv
`timescale 1ns/100ps
module hb_watchdog_test;
    localparam int T = 8;   // 1000 Hz * 8 ms / 1000

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hb_in = 1'b0;
    logic hb_float = 1'b0;
    logic sys_rst = 1'b1;
    logic pwr_ok = 1'b1;
    logic wdog_n;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    hb_watchdog #(.CLK_FREQ_HZ(64'd1000), .PERIOD_MS(64'd8), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .hb_in(hb_in), .hb_float(hb_float),
        .sys_rst(sys_rst), .pwr_ok(pwr_ok), .wdog_n(wdog_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic enter_hold(input bit lvl);
        sys_rst = 1'b1;
        hb_float = 1'b0;
        pwr_ok = 1'b1;
        hb_in = lvl;
        repeat (5) step();
    endtask

    // Release, toggle once after edge d, record low/high/low transitions.
    task automatic delay_run(input int d, input bit lvl,
                             output int lo1, output int hi1, output int lo2);
        enter_hold(lvl);
        sys_rst = 1'b0;
        lo1 = -1; hi1 = -1; lo2 = -1;
        if (d == 0) hb_in = ~hb_in;
        for (int n = 1; n <= 4*T + 6; n++) begin
            step();
            if (!wdog_n && lo1 < 0) lo1 = n;
            else if (wdog_n && lo1 >= 0 && hi1 < 0) hi1 = n;
            else if (!wdog_n && hi1 >= 0 && lo2 < 0) lo2 = n;
            if (n == d) hb_in = ~hb_in;
        end
    endtask

    // Periodic toggling with period p starting at release.
    task automatic period_run(input int p, output int lo1);
        enter_hold(1'b0);
        sys_rst = 1'b0;
        lo1 = -1;
        hb_in = ~hb_in;
        for (int n = 1; n <= 4*T; n++) begin
            step();
            if (!wdog_n && lo1 < 0) lo1 = n;
            if (n % p == 0) hb_in = ~hb_in;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lo1, hi1, lo2, first, ok_all;
        // R9: reset state
        repeat (3) step();
        chk(wdog_n == 1'b1, "R9 flag high in reset", wdog_n, 1);
        rst_n = 1'b1;
        step();
        chk(wdog_n == 1'b1, "R9 flag high after reset", wdog_n, 1);

        // R1, R5: no heartbeat at all
        enter_hold(1'b0);
        sys_rst = 1'b0;
        first = -1;
        for (int n = 1; n <= 2*T; n++) begin
            step();
            if (!wdog_n && first < 0) first = n;
        end
        chk(first == T + 1, "R1 R5 timeout from release", first, T + 1);

        // R2, R8: toggle-delay sweep, both starting levels (rising and falling)
        for (int lv = 0; lv < 2; lv++) begin
            for (int d = 0; d <= 2*T; d++) begin
                delay_run(d, lv[0], lo1, hi1, lo2);
                if (d + 3 <= T + 1) begin
                    chk(lo1 == d + 3 + T, "R2 trip after edge clear", lo1, d + 3 + T);
                    chk(hi1 == -1, "R2 no recovery needed", hi1, -1);
                end else begin
                    chk(lo1 == T + 1, "R1 trip before edge", lo1, T + 1);
                    chk(hi1 == d + 3, "R8 recovery on edge", hi1, d + 3);
                    chk(lo2 == d + 3 + T, "R8 count restarts from zero", lo2, d + 3 + T);
                end
            end
        end

        // R10: period sweep
        for (int p = 1; p <= T + 1; p++) begin
            period_run(p, lo1);
            if (p <= T) chk(lo1 == -1, "R10 fast heartbeat never trips", lo1, -1);
            else        chk(lo1 == T + 3, "R10 slow heartbeat trips", lo1, T + 3);
        end

        // R3: reset held long, heartbeat idle, never trips
        enter_hold(1'b0);
        ok_all = 1;
        for (int n = 0; n < 3*T; n++) begin
            step();
            if (!wdog_n) ok_all = 0;
        end
        chk(ok_all == 1, "R3 no trip while in reset", ok_all, 1);

        // R3: reset re-asserted mid-count restarts timing
        sys_rst = 1'b0;
        repeat (5) step();
        chk(wdog_n == 1'b1, "R3 flag high mid-count", wdog_n, 1);
        sys_rst = 1'b1;
        repeat (3) step();
        sys_rst = 1'b0;
        first = -1;
        for (int n = 1; n <= 2*T; n++) begin
            step();
            if (!wdog_n && first < 0) first = n;
        end
        chk(first == T + 1, "R3 timing restarts after reset", first, T + 1);

        // R6: supply dip mid-count, immediate low, count undisturbed
        enter_hold(1'b0);
        sys_rst = 1'b0;
        first = -1;
        for (int n = 1; n <= 2*T; n++) begin
            step();
            if (n == 2) begin
                pwr_ok = 1'b0;
                #1;
                chk(wdog_n == 1'b0, "R6 supply dip forces low", wdog_n, 0);
            end else if (n == 3) begin
                pwr_ok = 1'b1;
                #1;
                chk(wdog_n == 1'b1, "R6 flag back with supply", wdog_n, 1);
            end else if (!wdog_n && first < 0) begin
                first = n;
            end
        end
        chk(first == T + 1, "R6 count unaffected by dip", first, T + 1);

        // R4, R7: disconnected heartbeat acts as low-line indicator
        enter_hold(1'b0);
        hb_float = 1'b1;
        sys_rst = 1'b0;
        ok_all = 1;
        for (int n = 1; n <= 3*T; n++) begin
            step();
            if (n % 3 == 0) hb_in = ~hb_in;
            if (!wdog_n) ok_all = 0;
        end
        chk(ok_all == 1, "R4 no trip while disconnected", ok_all, 1);
        pwr_ok = 1'b0;
        #1;
        chk(wdog_n == 1'b0, "R7 low-line follows supply", wdog_n, 0);
        step();
        chk(wdog_n == 1'b0, "R7 low-line held", wdog_n, 0);
        pwr_ok = 1'b1;
        #1;
        chk(wdog_n == 1'b1, "R7 low-line released", wdog_n, 1);
        hb_float = 1'b0;
        hb_in = 1'b0;
        first = -1;
        for (int n = 1; n <= 3*T; n++) begin
            step();
            if (!wdog_n && first < 0) first = n;
        end
        chk(first > 0 && first <= T + 4, "R4 counting resumes after reconnect", first, T + 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule